// File: doc/BRIEF.md
# Dual-Pulse Up/Down Binary Counter

This block is a synchronous 4-bit binary counter with two count inputs. A pulse on one input counts up and a pulse on the other counts down. The direction comes from which input pulses. There is no direction pin. The block runs on a free-running system clock. Each count input passes through a two-stage synchronizer. A rising edge is recognised when one system-clock sample reads 0 and the next reads 1. An active-high clear and an active-low parallel load from a data bus take precedence over counting, in that order.

Two active-low outputs support cascading. The carry output falls while the count is at its maximum and the increment input is held low. The borrow output falls while the count is zero and the decrement input is held low. To build a wider counter, wire carry to the next stage's increment input and borrow to the next stage's decrement input. No other logic is needed, because the release of the count pulse also releases carry or borrow.

Top module: `dual_pulse_counter`

## Requirements
- R1: The count is 4 bits and wraps modulo 16: counting up from 15 gives 0, and counting down from 0 gives 15.
- R2: A rising edge on `inc_pin` adds one to `q` while the synchronized `dec_pin` is high. `q` changes on the third system-clock rising edge at or after which the pin reads high.
- R3: A rising edge on `dec_pin` subtracts one from `q` while the synchronized `inc_pin` is high, with the same latency as R2.
- R4: When `clr` is 1 at a clock edge, `q` becomes 0 at that edge, whatever `load_n`, `din`, `inc_pin` or `dec_pin` are doing.
- R5: When `clr` is 0 and `load_n` is 0 at a clock edge, `q` takes the value of `din` at that edge, and count edges have no effect.
- R6: `carry_n` is 0 exactly when `q` is 15 and the synchronized `inc_pin` is 0, meaning `inc_pin` has been low for at least two clock edges.
- R7: `borrow_n` is 0 exactly when `q` is 0 and the synchronized `dec_pin` is 0.
- R8: A count edge is dropped if `clr` was 1 or `load_n` was 0 at the clock edge before the one that would apply it.
- R9: If rising edges appear on both count inputs in the same cycle, or if one input rises while the other is synchronized low, `q` holds.
- R10: Reset (`rst_n` low) gives `q` = 0, `carry_n` = 1 and `borrow_n` = 1. Both synchronizers are preset to the idle high level, so releasing reset produces no count.
- R11: Two stages chained carry-to-increment and borrow-to-decrement form an 8-bit up/down counter. The upper stage's `carry_n` falls only at 255 and its `borrow_n` falls only at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inc_pin | input | 1 | Count-up input, idle high, counts on a rising edge |
| dec_pin | input | 1 | Count-down input, idle high, counts on a rising edge |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| load_n | input | 1 | Parallel load, active low |
| din | input | W (4) | Parallel load data |
| q | output | W (4) | Count value |
| carry_n | output | 1 | Active-low terminal-count pulse for up counting |
| borrow_n | output | 1 | Active-low terminal-count pulse for down counting |

## Verification
The assertions assume a count pulse is never released on both inputs in the same cycle. The one exception is the deliberate R9 stimulus, and that rule stops the count, so the single-step check still holds. They also assume each low and high phase of a count input lasts at least two system-clock cycles, so the synchronizers see every level.

The stimulus holds each phase for several cycles, longer than the two-stage cascade needs to settle. It changes load, clear and the count inputs only at the falling clock edge. It places the load release one edge after a pending count edge, to hit the R8 window exactly.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_INC   = 3'd1,
    ACT_DEC   = 3'd2,
    ACT_LOAD  = 3'd3,
    ACT_CLEAR = 3'd4
  } updn_act_e;

endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              hist_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  // preset high: the count inputs idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      hist_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~hist_q;

  // R9: a detected edge lasts a single cycle
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         up_rise,
  input  logic         dn_rise,
  input  logic         up_lvl,
  input  logic         dn_lvl,
  output logic [W-1:0] q
);

  updn_act_e    act;
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         q_en;
  logic         ctl_prev_q;
  logic         ctl_prev_d;

  always_comb begin
    act = ACT_HOLD;
    if (clr) begin
      act = ACT_CLEAR;
    end else if (!load_n) begin
      act = ACT_LOAD;
    end else if (!ctl_prev_q) begin
      if (up_rise && !dn_rise && dn_lvl) begin
        act = ACT_INC;
      end else if (dn_rise && !up_rise && up_lvl) begin
        act = ACT_DEC;
      end
    end
  end

  always_comb begin
    q_d = q_q;
    unique case (act)
      ACT_CLEAR: q_d = '0;
      ACT_LOAD:  q_d = din;
      ACT_INC:   q_d = q_q + 1'b1;
      ACT_DEC:   q_d = q_q - 1'b1;
      default:   q_d = q_q;
    endcase
    q_en       = (act != ACT_HOLD);
    ctl_prev_d = clr | ~load_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_prev_q <= 1'b0;
    end else begin
      ctl_prev_q <= ctl_prev_d;
    end
  end

  assign q = q_q;

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q_q == '0));

  a_r5_load_takes_din: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (q_q == $past(din)));

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n) |=> ((q_q == $past(q_q)) ||
                          (q_q == W'($past(q_q) + 1'b1)) ||
                          (q_q == W'($past(q_q) - 1'b1))));

  a_r9_both_edges_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rise && dn_rise && !clr && load_n) |=> $stable(q_q));

  a_r8_recent_control_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && ($past(clr) || !$past(load_n))) |=> $stable(q_q));

endmodule

// File: rtl/updn_cascade_out.sv
module updn_cascade_out #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         up_lvl,
  input  logic         dn_lvl,
  output logic         carry_n,
  output logic         borrow_n
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_comb begin
    carry_n  = ~((q == TOP) & ~up_lvl);
    borrow_n = ~((q == '0) & ~dn_lvl);
  end

endmodule

// File: rtl/dual_pulse_counter.sv
module dual_pulse_counter #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_pin,
  input  logic         dec_pin,
  input  logic         clr,
  input  logic         load_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry_n,
  output logic         borrow_n
);

  localparam int           NPIN = 2;
  localparam logic [W-1:0] TOP  = {W{1'b1}};

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NPIN-1:0] pin_vec;
  logic [NPIN-1:0] lvl_vec;
  logic [NPIN-1:0] rise_vec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign pin_vec = {dec_pin, inc_pin};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    updn_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_int_n),
      .pin   (pin_vec[i]),
      .level (lvl_vec[i]),
      .rise  (rise_vec[i])
    );
  end

  updn_count_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (clr),
    .load_n  (load_n),
    .din     (din),
    .up_rise (rise_vec[0]),
    .dn_rise (rise_vec[1]),
    .up_lvl  (lvl_vec[0]),
    .dn_lvl  (lvl_vec[1]),
    .q       (q)
  );

  updn_cascade_out #(.W(W)) u_out (
    .q        (q),
    .up_lvl   (lvl_vec[0]),
    .dn_lvl   (lvl_vec[1]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  a_r6_carry_at_top: assert property (@(posedge clk) disable iff (!rst_int_n)
    !carry_n |-> (q == TOP));

  a_r7_borrow_at_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !borrow_n |-> (q == '0));

  a_r10_idle_no_terminal: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inc_pin && $past(inc_pin) && $past(inc_pin, 2)) |-> carry_n);

endmodule

// File: tb/dual_pulse_counter_tb.sv
module dual_pulse_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n, inc, dec, clr, load_n;
  logic [7:0] din;
  logic [3:0] q_lo, q_hi;
  logic       c0, b0, c1, b1;
  int         checks = 0;
  int         errors = 0;
  int         model  = 0;

  always #5 clk = ~clk;

  dual_pulse_counter u_dut (
    .clk(clk), .rst_n(rst_n), .inc_pin(inc), .dec_pin(dec), .clr(clr),
    .load_n(load_n), .din(din[3:0]), .q(q_lo), .carry_n(c0), .borrow_n(b0)
  );

  dual_pulse_counter u_dut_hi (
    .clk(clk), .rst_n(rst_n), .inc_pin(c0), .dec_pin(b0), .clr(clr),
    .load_n(load_n), .din(din[7:4]), .q(q_hi), .carry_n(c1), .borrow_n(b1)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic pulse_up();
    @(negedge clk);
    inc = 1'b0;
    settle(6);
    chk("R6 carry low stage", int'(c0), (model % 16 == 15) ? 0 : 1);
    chk("R11 carry high stage", int'(c1), (model == 255) ? 0 : 1);
    inc = 1'b1;
    settle(10);
    model = (model + 1) % 256;
    chk("R2 R1 count up", int'({q_hi, q_lo}), model);
  endtask

  task automatic pulse_dn();
    @(negedge clk);
    dec = 1'b0;
    settle(6);
    chk("R7 borrow low stage", int'(b0), (model % 16 == 0) ? 0 : 1);
    chk("R11 borrow high stage", int'(b1), (model == 0) ? 0 : 1);
    dec = 1'b1;
    settle(10);
    model = (model + 255) % 256;
    chk("R3 R1 count down", int'({q_hi, q_lo}), model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; inc = 1'b1; dec = 1'b1; clr = 1'b0; load_n = 1'b1; din = 8'h00;
    settle(3);
    chk("R10 reset q", int'({q_hi, q_lo}), 0);
    chk("R10 reset carry", int'(c0), 1);
    chk("R10 reset borrow", int'(b0), 1);
    rst_n = 1'b1;
    settle(6);
    chk("R10 no count at release", int'({q_hi, q_lo}), 0);

    for (int i = 0; i < 260; i++) pulse_up();
    for (int i = 0; i < 260; i++) pulse_dn();

    // R5: load, and counts ignored while load is low
    din = 8'h42; load_n = 1'b0;
    settle(2);
    chk("R5 load value", int'({q_hi, q_lo}), 8'h42);
    inc = 1'b0; settle(4); inc = 1'b1; settle(6);
    chk("R5 count ignored under load", int'({q_hi, q_lo}), 8'h42);
    load_n = 1'b1;
    settle(3);
    chk("R5 value kept after load", int'({q_hi, q_lo}), 8'h42);

    // R4: clear beats load
    din = 8'h99; load_n = 1'b0; clr = 1'b1;
    settle(2);
    chk("R4 clear over load", int'({q_hi, q_lo}), 0);
    clr = 1'b0;
    settle(2);
    chk("R5 load after clear", int'({q_hi, q_lo}), 8'h99);

    // R8: count edge right after load release is dropped
    din = 8'h35;
    inc = 1'b0;
    settle(4);
    inc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    load_n = 1'b1;
    settle(8);
    model = 8'h35;
    chk("R8 edge after control dropped", int'({q_hi, q_lo}), model);
    pulse_up();

    // R9: simultaneous rises hold
    @(negedge clk);
    inc = 1'b0; dec = 1'b0;
    settle(6);
    inc = 1'b1; dec = 1'b1;
    settle(10);
    chk("R9 simultaneous edges", int'({q_hi, q_lo}), model);

    // R9: rise while the other input is low holds; later dec release counts (R3)
    dec = 1'b0; settle(4);
    inc = 1'b0; settle(4);
    inc = 1'b1; settle(8);
    chk("R9 edge with other low", int'({q_hi, q_lo}), model);
    dec = 1'b1; settle(10);
    model = (model + 255) % 256;
    chk("R3 dec release counts", int'({q_hi, q_lo}), model);

    finish_run();
  end

endmodule